// File: doc/BRIEF.md
# Nine-Bit Serial Transceiver Core

This block is an asynchronous serial transmitter and receiver pair for one host. Characters are framed as one low start bit, eight data bits sent least significant bit first, and one high stop bit. A single mode input switches both directions at once to nine-bit characters. In that mode an extra data bit follows bit 7 and precedes the stop bit. The host loads characters through a one-deep transmit buffer. The ninth transmit bit comes from its own sticky latch. That latch is copied into the shift register in the same cycle that the buffer moves into it, so a host that writes the ninth bit before the byte always sends a coherent character. A run of characters that share the same ninth bit needs only the byte writes.

The receiver samples the line at sixteen times the bit rate and keeps the majority of three samples taken around mid-bit. A received character is presented as a byte plus a separate ninth bit, with status flags for full, framing error and overrun. A programmable divisor sets the oversampling tick. A falling-edge detector on the receive line sets an edge flag at any time, and that flag drives a maskable wake output. Two request outputs, one for transmit-buffer-empty and one for receive-full, serve a DMA engine or an interrupt controller with a done handshake.

Transmit state machine: TX_IDLE goes to TX_START when the buffer holds a character (the load). TX_START goes to TX_DATA after one bit time. TX_DATA goes to TX_STOP after the last data bit. TX_STOP goes back to TX_IDLE after one bit time. Receive state machine: RX_IDLE goes to RX_START on a tick that sees the line low. RX_START goes to RX_DATA if the start bit reads low at mid-bit, and otherwise back to RX_IDLE. RX_DATA goes to RX_STOP after the last data bit. RX_STOP goes back to RX_IDLE and delivers the character. Request state machine, one per channel: DQ_IDLE goes to DQ_REQ while its condition holds. DQ_REQ goes to DQ_HOLD on done, or back to DQ_IDLE when the condition drops. DQ_HOLD always goes to DQ_IDLE.

Top module: `uart9_core`

## Requirements
- R1: After reset, txd is high, tx_empty is 1, and rx_full, frame_err, overrun, edge_flag and wake are all 0.
- R2: A frame on txd is start (0), then data bits LSB first (8 of them, or 9 when mode9 is 1, with the ninth bit taken from the ninth-bit latch and sent after bit 7), then stop (1).
- R3: The transmit ninth-bit latch keeps its value across characters. A character written without a new tx_ninth_wr uses the last latched value.
- R4: The ninth-bit latch is sampled when the buffer moves into the shifter. A tx_ninth_wr after that move does not change the character already being sent.
- R5: tx_empty clears in the cycle after tx_wr and sets again when the buffer is loaded into the shifter.
- R6: A received character shows on rx_data, with its ninth bit on rx_ninth (0 for 8-bit characters). rx_full sets at the stop bit and clears after rx_rd.
- R7: Each bit is the majority of the 3 samples at oversample positions 7, 8 and 9. A start bit that is not low at mid-bit is dropped and delivers nothing.
- R8: A stop bit read as 0 sets frame_err, and the character is still stored. rx_rd clears frame_err.
- R9: A character that completes while rx_full is 1 sets overrun and is discarded, so rx_data keeps the older character. rx_rd clears overrun.
- R10: A falling edge on rxd sets edge_flag, whatever the receiver state. edge_clr clears it. wake equals edge_flag AND edge_en.
- R11: Each request output follows its condition (tx_empty, rx_full). It goes low in the two cycles after a done pulse, and it is high again after the third clock edge if the condition still holds.
- R12: One bit lasts 16 × baud_div clock cycles. A baud_div of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | DIV_W | Cycles per oversampling tick |
| mode9 | input | 1 | 1 selects nine-bit characters for both directions |
| tx_ninth_wr | input | 1 | Strobe that writes the transmit ninth-bit latch |
| tx_ninth_in | input | 1 | Value for the ninth-bit latch |
| tx_wr | input | 1 | Strobe that writes the transmit buffer |
| tx_data | input | DATA_W | Byte for the transmit buffer |
| rx_rd | input | 1 | Read strobe that clears rx_full, frame_err and overrun |
| rx_data | output | DATA_W | Last stored received byte |
| rx_ninth | output | 1 | Ninth bit of the last stored character |
| tx_empty | output | 1 | Transmit buffer can accept a byte |
| rx_full | output | 1 | Received character waiting |
| frame_err | output | 1 | Stored character had a low stop bit |
| overrun | output | 1 | A character was lost because rx_full was set |
| edge_clr | input | 1 | Clears edge_flag |
| edge_en | input | 1 | Lets edge_flag drive wake |
| edge_flag | output | 1 | A falling edge was seen on rxd |
| wake | output | 1 | Masked edge event |
| tx_dma_req | output | 1 | Transmit-empty request |
| tx_dma_done | input | 1 | Transmit request served |
| rx_dma_req | output | 1 | Receive-full request |
| rx_dma_done | input | 1 | Receive request served |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input |

## Verification
The bench builds the core with its default parameters: 8-bit bytes, a 13-bit divisor and 16× oversampling. At run time it sets baud_div to 2, so a bit lasts 32 cycles and an 11-bit nine-bit frame lasts 352 cycles. With frames that short, the bench can send back-to-back transmit characters, stage ninth-bit rewrites mid-character, make a second receive character overrun the first, and repeat the request re-arm handshake, all within a few thousand cycles. A divisor of 2 also gives a distinct 32-cycle bit period that the bench measures edge to edge on txd.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
    typedef enum logic [1:0] {DQ_IDLE, DQ_REQ, DQ_HOLD} dq_state_t;

    // two-of-three vote over the mid-bit samples
    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

endpackage

// File: rtl/uart9_baud.sv
module uart9_baud #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;
    logic             wrap;

    assign lim  = (div == '0) ? ONE : div;
    assign wrap = (cnt >= lim - ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (wrap) cnt <= '0;
        else           cnt <= cnt + ONE;
    end

    assign tick = wrap;

endmodule

// File: rtl/uart9_tx.sv
module uart9_tx import uart9_pkg::*; #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              mode9,
    input  logic              buf_valid,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              ninth,
    output logic              load,
    output logic              txd
);
    localparam int SH_W = DATA_W + 1;
    localparam int TC_W = $clog2(OVS);
    localparam int BC_W = $clog2(SH_W);
    localparam logic [TC_W-1:0] TC_LAST = TC_W'(OVS - 1);
    localparam logic [TC_W-1:0] TC_ONE  = TC_W'(1);
    localparam logic [BC_W-1:0] BC_ONE  = BC_W'(1);
    localparam logic [BC_W-1:0] LAST9   = BC_W'(SH_W - 1);
    localparam logic [BC_W-1:0] LAST8   = BC_W'(DATA_W - 1);

    tx_state_t       state, nxt;
    logic [TC_W-1:0] tcnt;
    logic [BC_W-1:0] bcnt;
    logic [BC_W-1:0] last_bit;
    logic [SH_W-1:0] sh;
    logic            bit_end;

    assign bit_end = tick && (tcnt == TC_LAST);
    assign load    = (state == TX_IDLE) && buf_valid;

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (buf_valid) nxt = TX_START;
            TX_START: if (bit_end) nxt = TX_DATA;
            TX_DATA:  if (bit_end && (bcnt == last_bit)) nxt = TX_STOP;
            TX_STOP:  if (bit_end) nxt = TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt     <= '0;
            bcnt     <= '0;
            last_bit <= LAST8;
            sh       <= '0;
        end else if (load) begin
            // ninth latch and buffer are captured together
            sh       <= {ninth, buf_data};
            last_bit <= mode9 ? LAST9 : LAST8;
            tcnt     <= '0;
            bcnt     <= '0;
        end else if ((state != TX_IDLE) && tick) begin
            tcnt <= bit_end ? '0 : tcnt + TC_ONE;
            if (bit_end && (state == TX_DATA)) begin
                sh   <= sh >> 1;
                bcnt <= bcnt + BC_ONE;
            end
        end
    end

    always_comb begin
        unique case (state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh[0];
            default:  txd = 1'b1;
        endcase
    end

    // R2: the stop bit is always high
    assert_stop_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_STOP) |-> txd);

    // R4: the shifted character is frozen between shifts
    assert_shift_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == TX_DATA) && !bit_end) |=> $stable(sh));

endmodule

// File: rtl/uart9_rx.sv
module uart9_rx import uart9_pkg::*; #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              mode9,
    input  logic              rxd_s,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              ninth,
    output logic              stop_ok
);
    localparam int SH_W = DATA_W + 1;
    localparam int TC_W = $clog2(OVS);
    localparam int BC_W = $clog2(SH_W);
    localparam int MID  = OVS / 2;
    localparam logic [TC_W-1:0] TC_LAST = TC_W'(OVS - 1);
    localparam logic [TC_W-1:0] TC_ONE  = TC_W'(1);
    localparam logic [TC_W-1:0] SMP_A   = TC_W'(MID - 1);
    localparam logic [TC_W-1:0] SMP_B   = TC_W'(MID);
    localparam logic [TC_W-1:0] SMP_C   = TC_W'(MID + 1);
    localparam logic [BC_W-1:0] BC_ONE  = BC_W'(1);
    localparam logic [BC_W-1:0] LAST9   = BC_W'(SH_W - 1);
    localparam logic [BC_W-1:0] LAST8   = BC_W'(DATA_W - 1);

    rx_state_t         state, nxt;
    logic [TC_W-1:0]   scnt;
    logic [BC_W-1:0]   bcnt;
    logic [BC_W-1:0]   last_bit;
    logic [2:0]        samp;
    logic [SH_W-1:0]   sh;
    logic              mode_q;
    logic              bit_end;
    logic              bitv;
    logic              done_q, stop_q, ninth_q;
    logic [DATA_W-1:0] data_q;

    assign bit_end = tick && (scnt == TC_LAST);
    assign bitv    = vote3(samp);

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (tick && !rxd_s) nxt = RX_START;
            RX_START: if (bit_end) nxt = bitv ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_end && (bcnt == last_bit)) nxt = RX_STOP;
            RX_STOP:  if (bit_end) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scnt     <= '0;
            bcnt     <= '0;
            last_bit <= LAST8;
            samp     <= 3'b111;
            sh       <= '0;
            mode_q   <= 1'b0;
            done_q   <= 1'b0;
            stop_q   <= 1'b1;
            ninth_q  <= 1'b0;
            data_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (state == RX_IDLE) begin
                if (tick && !rxd_s) begin
                    scnt     <= TC_ONE;
                    bcnt     <= '0;
                    mode_q   <= mode9;
                    last_bit <= mode9 ? LAST9 : LAST8;
                end
            end else if (tick) begin
                scnt <= bit_end ? '0 : scnt + TC_ONE;
                if (scnt == SMP_A) samp[0] <= rxd_s;
                if (scnt == SMP_B) samp[1] <= rxd_s;
                if (scnt == SMP_C) samp[2] <= rxd_s;
                if (bit_end && (state == RX_DATA)) begin
                    sh   <= {bitv, sh[SH_W-1:1]};
                    bcnt <= bcnt + BC_ONE;
                end
                if (bit_end && (state == RX_STOP)) begin
                    done_q  <= 1'b1;
                    stop_q  <= bitv;
                    data_q  <= mode_q ? sh[DATA_W-1:0] : sh[SH_W-1:1];
                    ninth_q <= mode_q & sh[SH_W-1];
                end
            end
        end
    end

    assign done    = done_q;
    assign data    = data_q;
    assign ninth   = ninth_q;
    assign stop_ok = stop_q;

    // R6: eight-bit characters never report a ninth bit
    assert_ninth_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode_q) |-> !ninth);

    // R7: a start bit read high at mid-bit returns to idle with no delivery
    assert_false_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == RX_START) && bit_end && bitv) |=> ((state == RX_IDLE) && !done));

endmodule

// File: rtl/uart9_edge.sv
module uart9_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    input  logic clr,
    input  logic en,
    output logic rxd_s,
    output logic flag,
    output logic wake
);
    logic s1, s2, prev, flag_q, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1   <= 1'b1;
            s2   <= 1'b1;
            prev <= 1'b1;
        end else begin
            s1   <= rxd;
            s2   <= s1;
            prev <= s2;
        end
    end

    assign fall = prev & ~s2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    flag_q <= 1'b0;
        else if (fall) flag_q <= 1'b1;
        else if (clr)  flag_q <= 1'b0;
    end

    assign rxd_s = s2;
    assign flag  = flag_q;
    assign wake  = flag_q & en;

    // R10: a set flag stays set until cleared
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R10: wake is silent while the mask is off
    assert_wake_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !wake);

endmodule

// File: rtl/uart9_dq.sv
module uart9_dq import uart9_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic done,
    output logic req
);
    dq_state_t state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            DQ_IDLE: if (cond) nxt = DQ_REQ;
            DQ_REQ:  if (done) nxt = DQ_HOLD;
                     else if (!cond) nxt = DQ_IDLE;
            DQ_HOLD: nxt = DQ_IDLE;
            default: nxt = DQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DQ_IDLE;
        else        state <= nxt;
    end

    always_comb req = (state == DQ_REQ);

    // R11: done withdraws the request
    assert_req_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req && done) |=> !req);

    // R11: no request outlives its condition
    assert_req_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> !req);

endmodule

// File: rtl/uart9_core.sv
module uart9_core import uart9_pkg::*; #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 13,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              mode9,
    input  logic              tx_ninth_wr,
    input  logic              tx_ninth_in,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ninth,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              frame_err,
    output logic              overrun,
    input  logic              edge_clr,
    input  logic              edge_en,
    output logic              edge_flag,
    output logic              wake,
    output logic              tx_dma_req,
    input  logic              tx_dma_done,
    output logic              rx_dma_req,
    input  logic              rx_dma_done,
    output logic              txd,
    input  logic              rxd
);
    localparam int NUM_DQ = 2;

    logic              tick, load;
    logic [DATA_W-1:0] tx_buf;
    logic              ninth_latch;
    logic              empty_q;
    logic              rxd_s;
    logic              rx_done, rx_b9, rx_stop_ok;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] rx_buf;
    logic              rx_b9_q, full_q, ferr_q, ovr_q;
    logic [NUM_DQ-1:0] dq_cond, dq_done, dq_req;

    uart9_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
    );

    uart9_edge u_edge (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .clr(edge_clr), .en(edge_en),
        .rxd_s(rxd_s), .flag(edge_flag), .wake(wake)
    );

    uart9_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode9(mode9),
        .buf_valid(!empty_q), .buf_data(tx_buf), .ninth(ninth_latch),
        .load(load), .txd(txd)
    );

    uart9_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode9(mode9), .rxd_s(rxd_s),
        .done(rx_done), .data(rx_byte), .ninth(rx_b9), .stop_ok(rx_stop_ok)
    );

    // transmit buffer, empty flag and sticky ninth-bit latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_buf      <= '0;
            empty_q     <= 1'b1;
            ninth_latch <= 1'b0;
        end else begin
            if (tx_ninth_wr) ninth_latch <= tx_ninth_in;
            if (tx_wr) begin
                tx_buf  <= tx_data;
                empty_q <= 1'b0;
            end else if (load) begin
                empty_q <= 1'b1;
            end
        end
    end

    // receive holding register and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_buf  <= '0;
            rx_b9_q <= 1'b0;
            full_q  <= 1'b0;
            ferr_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (rx_rd) begin
                full_q <= 1'b0;
                ferr_q <= 1'b0;
                ovr_q  <= 1'b0;
            end
            if (rx_done) begin
                if (full_q && !rx_rd) begin
                    ovr_q <= 1'b1;
                end else begin
                    rx_buf  <= rx_byte;
                    rx_b9_q <= rx_b9;
                    full_q  <= 1'b1;
                    ferr_q  <= !rx_stop_ok;
                end
            end
        end
    end

    assign dq_cond = {full_q, empty_q};
    assign dq_done = {rx_dma_done, tx_dma_done};

    for (genvar g = 0; g < NUM_DQ; g++) begin : g_dq
        uart9_dq u_dq (
            .clk(clk), .rst_n(rst_n), .cond(dq_cond[g]),
            .done(dq_done[g]), .req(dq_req[g])
        );
    end

    assign tx_dma_req = dq_req[0];
    assign rx_dma_req = dq_req[1];
    assign tx_empty   = empty_q;
    assign rx_full    = full_q;
    assign frame_err  = ferr_q;
    assign overrun    = ovr_q;
    assign rx_data    = rx_buf;
    assign rx_ninth   = rx_b9_q;

    // R5: a data write always leaves the buffer marked occupied
    assert_empty_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !tx_empty);

    // R5: the empty flag returns only through a shifter load
    assert_empty_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> $past(load));

    // R6: rx_full rises only on a delivered character
    assert_full_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(rx_done));

    // R9: an overrun leaves the held character untouched
    assert_overrun_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $stable(rx_data));

endmodule

// File: tb/uart9_core_tb.sv
`timescale 1ns/1ps
module uart9_core_tb;
    localparam int DIV   = 2;
    localparam int BIT_T = 16 * DIV;
    localparam int NVEC  = 6;
    // vector fields: {mode9, ninth, stop level, byte}
    localparam logic [10:0] VECS [NVEC] = '{
        {1'b0, 1'b0, 1'b1, 8'hA5},
        {1'b1, 1'b1, 1'b1, 8'h3C},
        {1'b1, 1'b0, 1'b1, 8'hFF},
        {1'b0, 1'b1, 1'b1, 8'h00},
        {1'b1, 1'b1, 1'b0, 8'h81},
        {1'b0, 1'b0, 1'b0, 8'h7E}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] baud_div = 13'(DIV);
    logic        mode9 = 1'b0;
    logic        tx_ninth_wr = 1'b0, tx_ninth_in = 1'b0;
    logic        tx_wr = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic        rx_rd = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_ninth, tx_empty, rx_full, frame_err, overrun;
    logic        edge_clr = 1'b0, edge_en = 1'b0, edge_flag, wake;
    logic        tx_dma_req, rx_dma_req;
    logic        tx_dma_done = 1'b0, rx_dma_done = 1'b0;
    logic        txd;
    logic        rxd = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    uart9_core u_dut (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .mode9(mode9),
        .tx_ninth_wr(tx_ninth_wr), .tx_ninth_in(tx_ninth_in),
        .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
        .rx_data(rx_data), .rx_ninth(rx_ninth), .tx_empty(tx_empty),
        .rx_full(rx_full), .frame_err(frame_err), .overrun(overrun),
        .edge_clr(edge_clr), .edge_en(edge_en), .edge_flag(edge_flag),
        .wake(wake), .tx_dma_req(tx_dma_req), .tx_dma_done(tx_dma_done),
        .rx_dma_req(rx_dma_req), .rx_dma_done(rx_dma_done),
        .txd(txd), .rxd(rxd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_ninth(input logic v);
        @(negedge clk); tx_ninth_in = v; tx_ninth_wr = 1'b1;
        @(negedge clk); tx_ninth_wr = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] d);
        @(negedge clk); tx_data = d; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic rd_pulse();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 50 && !tx_empty; i++) @(negedge clk);
    endtask

    // capture one character from txd, sampling at mid-bit
    task automatic capture_tx(input logic m9, output logic [8:0] bits, output logic stop);
        int nb;
        nb = m9 ? 9 : 8;
        bits = '0;
        for (int i = 0; i < 4000 && txd; i++) @(negedge clk);
        repeat (BIT_T / 2) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            repeat (BIT_T) @(negedge clk);
            bits[i] = txd;
        end
        repeat (BIT_T) @(negedge clk);
        stop = txd;
    endtask

    task automatic send_rx(input logic m9, input logic [8:0] bits, input logic stop);
        int nb;
        nb = m9 ? 9 : 8;
        @(negedge clk); rxd = 1'b0;
        repeat (BIT_T) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rxd = bits[i];
            repeat (BIT_T) @(negedge clk);
        end
        rxd = stop;
        repeat (BIT_T) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT_T / 2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [8:0] got;
        logic       stp;
        logic [8:0] exp9;
        int         cnt;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state
        chk("R1 txd idle", txd, 1);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 rx_full", rx_full, 0);
        chk("R1 frame_err", frame_err, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 edge_flag", edge_flag, 0);
        chk("R1 wake", wake, 0);
        chk("R11 tx req on empty", tx_dma_req, 1);
        chk("R11 rx req idle", rx_dma_req, 0);

        // vector walk: transmit then receive each character
        for (int v = 0; v < NVEC; v++) begin
            logic m9, n9, sl;
            logic [7:0] d;
            {m9, n9, sl, d} = VECS[v];
            mode9 = m9;
            exp9 = m9 ? {n9, d} : {1'b0, d};
            wr_ninth(n9);
            wr_data(d);
            capture_tx(m9, got, stp);
            chk("R2 tx character bits", 32'(got), 32'(exp9));
            chk("R2 tx stop high", stp, 1);
            send_rx(m9, {n9, d}, sl);
            chk("R6 rx_full set", rx_full, 1);
            chk("R6 rx_data", rx_data, d);
            chk("R6 rx_ninth", rx_ninth, m9 ? n9 : 1'b0);
            chk("R8 frame_err", frame_err, !sl);
            rd_pulse();
            chk("R6 rx_full cleared by read", rx_full, 0);
            chk("R8 frame_err cleared by read", frame_err, 0);
            repeat (2 * BIT_T) @(negedge clk);
        end

        // R12: bit period from a data-bit edge pair of 0x55
        mode9 = 1'b0;
        wr_data(8'h55);
        for (int i = 0; i < 200 && txd; i++) @(negedge clk);
        for (int i = 0; i < 200 && !txd; i++) @(negedge clk);
        cnt = 0;
        while (txd && cnt < 1000) begin @(negedge clk); cnt++; end
        chk("R12 bit period cycles", cnt, BIT_T);
        repeat (12 * BIT_T) @(negedge clk);

        // R5, R3: back-to-back characters share a latched ninth bit
        mode9 = 1'b1;
        wr_ninth(1'b1);
        wr_data(8'h5A);
        chk("R5 tx_empty cleared by write", tx_empty, 0);
        wait_empty();
        chk("R5 tx_empty set on load", tx_empty, 1);
        wr_data(8'hC3);
        capture_tx(1'b1, got, stp);
        chk("R3 first char ninth", 32'(got), 32'({1'b1, 8'h5A}));
        capture_tx(1'b1, got, stp);
        chk("R3 second char keeps ninth", 32'(got), 32'({1'b1, 8'hC3}));
        repeat (3 * BIT_T) @(negedge clk);

        // R4: rewriting the latch after load leaves the shifting character alone
        wr_data(8'h96);
        wait_empty();
        wr_ninth(1'b0);
        capture_tx(1'b1, got, stp);
        chk("R4 in-flight char ninth unchanged", 32'(got), 32'({1'b1, 8'h96}));
        wr_data(8'h69);
        capture_tx(1'b1, got, stp);
        chk("R3 next char takes new ninth", 32'(got), 32'({1'b0, 8'h69}));
        repeat (3 * BIT_T) @(negedge clk);

        // R10: edge flag and wake mask
        mode9 = 1'b0;
        @(negedge clk); edge_clr = 1'b1;
        @(negedge clk); edge_clr = 1'b0;
        chk("R10 edge_flag cleared", edge_flag, 0);
        // R7: short low pulse is a false start
        @(negedge clk); rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BIT_T) @(negedge clk);
        chk("R7 glitch delivers nothing", rx_full, 0);
        chk("R10 edge_flag set by falling edge", edge_flag, 1);
        chk("R10 wake masked", wake, 0);
        @(negedge clk); edge_en = 1'b1;
        @(negedge clk);
        chk("R10 wake enabled", wake, 1);
        @(negedge clk); edge_clr = 1'b1;
        @(negedge clk); edge_clr = 1'b0;
        chk("R10 wake after clear", wake, 0);
        edge_en = 1'b0;

        // R9: second character while full is dropped
        send_rx(1'b0, 9'h011, 1'b1);
        repeat (BIT_T) @(negedge clk);
        send_rx(1'b0, 9'h022, 1'b1);
        chk("R9 overrun set", overrun, 1);
        chk("R9 older byte kept", rx_data, 8'h11);
        chk("R9 rx_full still set", rx_full, 1);

        // R11: receive request re-arms while full
        chk("R11 rx req while full", rx_dma_req, 1);
        @(negedge clk); rx_dma_done = 1'b1;
        @(negedge clk); rx_dma_done = 1'b0;
        chk("R11 rx req low after done", rx_dma_req, 0);
        @(negedge clk);
        chk("R11 rx req low second cycle", rx_dma_req, 0);
        @(negedge clk);
        chk("R11 rx req re-raised", rx_dma_req, 1);
        rd_pulse();
        chk("R9 overrun cleared by read", overrun, 0);
        @(negedge clk);
        chk("R11 rx req gone after read", rx_dma_req, 0);

        // R11: transmit request handshake while empty
        repeat (4) @(negedge clk);
        chk("R11 tx req while empty", tx_dma_req, 1);
        @(negedge clk); tx_dma_done = 1'b1;
        @(negedge clk); tx_dma_done = 1'b0;
        chk("R11 tx req low after done", tx_dma_req, 0);
        @(negedge clk);
        chk("R11 tx req low second cycle", tx_dma_req, 0);
        @(negedge clk);
        chk("R11 tx req re-raised", tx_dma_req, 1);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule